// File: doc/BRIEF.md
# Three-Read-Port Register File with Product Pair

This block is the 32 x 32-bit register array of a small processor datapath. Three read ports return register contents combinationally. An address change shows on the matching data output within the same cycle, with no clock involved. A single general write port stores one word on the falling clock edge when its enable is high.

A separate 64-bit product input, with its own enable, loads a long-multiply result into the two topmost entries on that same falling edge. The upper half goes to entry 30 and the lower half to entry 31. Entries 0 to 29 are general purpose.

Writes are always accepted, so neither write path has back-pressure. Every pin is a plain level, sampled at the falling edge. Reset is synchronous to the falling edge and clears the whole array.

Top module: `regbank3r`

## Requirements
- R1: A falling edge with `rst` high sets all 32 entries to zero, and this holds whatever the write inputs are doing.
- R2: Each of the three read ports returns the entry selected by its own 5-bit address. An address change shows at the output without any clock edge, and the three ports work independently.
- R3: On a falling edge with `wr_en` high and `rst` low, entry `wr_addr` takes `wr_data`. This applies to any address 0 to 31, as long as no product write claims that entry.
- R4: On a falling edge with `wr_en` and `mul_en` both low, no entry changes.
- R5: On a falling edge with `mul_en` high and `rst` low, entry 30 takes `mul_data[63:32]` and entry 31 takes `mul_data[31:0]`.
- R6: When a product write and a general write to entry 30 or 31 fall on the same edge, the product halves win. A general write to any entry from 0 to 29 still completes on that edge.
- R7: Between rising and falling edges, reads return the value an entry held before the pending write. Right after the falling edge, the new value is visible, and a rising edge alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the array updates on its falling edge |
| rst | input | 1 | Synchronous clear, active high, sampled at the falling edge |
| rd0_addr | input | 5 | Read port 0 address |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 5 | Read port 1 address |
| rd1_data | output | 32 | Read port 1 data |
| rd2_addr | input | 5 | Read port 2 address |
| rd2_data | output | 32 | Read port 2 data |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 5 | General write address |
| wr_data | input | 32 | General write data |
| mul_en | input | 1 | Product write enable |
| mul_data | input | 64 | Product; the upper half goes to entry 30, the lower half to entry 31 |

## Verification
The assertions assume that the write inputs are settled and free of X or Z at every falling edge. They also assume that reset is held for at least one falling edge before any write check counts. The bench changes every input only a couple of nanoseconds after a rising edge, which leaves half a period of stable levels before the falling edge. It starts with reset high, and when it asserts reset again later it does so at that same point in the cycle. Random addresses cover all 32 entries, product enables and general writes aimed at entries 30 and 31 are mixed in often enough to collide, and idle cycles are included.

// File: rtl/rb_pkg.sv
package rb_pkg;
  // Source chosen for one array entry on the next falling edge
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_GEN    = 2'd1,
    SRC_MUL_HI = 2'd2,
    SRC_MUL_LO = 2'd3
  } wr_src_e;
endpackage

// File: rtl/rb_cell.sv
module rb_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(negedge clk) begin
    if (rst)      q <= '0;
    else if (sel) q <= d;
  end

  // R1: the edge after a reset edge shows a cleared entry
  assert_cell_reset_R1: assert property (@(negedge clk) disable iff (rst)
    $past(rst) |-> (q == '0));

  // R3: a selected entry holds the offered word one edge later
  assert_cell_load_R3: assert property (@(negedge clk) disable iff (rst)
    ($past(sel) && !$past(rst)) |-> (q == $past(d)));

  // R4: an unselected entry keeps its value
  assert_cell_hold_R4: assert property (@(negedge clk) disable iff (rst)
    (!$past(sel) && !$past(rst)) |-> $stable(q));
endmodule

// File: rtl/rb_wr_select.sv
module rb_wr_select
  import rb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             mul_en,
  input  logic [2*DATA_W-1:0]              mul_data,
  output logic [NUM_REGS-1:0]              sel,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  din
);
  localparam int HI_IDX = NUM_REGS - 2;
  localparam int LO_IDX = NUM_REGS - 1;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    wr_src_e src;

    always_comb begin
      src = SRC_NONE;
      // Product halves outrank the general port on the reserved pair
      if (mul_en && (i == HI_IDX))                  src = SRC_MUL_HI;
      else if (mul_en && (i == LO_IDX))             src = SRC_MUL_LO;
      else if (wr_en && (wr_addr == ADDR_W'(i)))    src = SRC_GEN;
    end

    always_comb begin
      unique case (src)
        SRC_MUL_HI: din[i] = mul_data[2*DATA_W-1:DATA_W];
        SRC_MUL_LO: din[i] = mul_data[DATA_W-1:0];
        SRC_GEN:    din[i] = wr_data;
        default:    din[i] = '0;
      endcase
    end

    assign sel[i] = (src != SRC_NONE);
  end
endmodule

// File: rtl/rb_read_mux.sv
module rb_read_mux #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] mem,
  input  logic [ADDR_W-1:0]               addr,
  output logic [DATA_W-1:0]               data
);
  always_comb data = mem[addr];
endmodule

// File: rtl/regbank3r.sv
module regbank3r #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   rd0_addr,
  output logic [DATA_W-1:0]   rd0_data,
  input  logic [ADDR_W-1:0]   rd1_addr,
  output logic [DATA_W-1:0]   rd1_data,
  input  logic [ADDR_W-1:0]   rd2_addr,
  output logic [DATA_W-1:0]   rd2_data,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                mul_en,
  input  logic [2*DATA_W-1:0] mul_data
);
  localparam int NUM_RD = 3;
  localparam int HI_IDX = NUM_REGS - 2;
  localparam int LO_IDX = NUM_REGS - 1;

  logic [NUM_REGS-1:0][DATA_W-1:0] mem;
  logic [NUM_REGS-1:0][DATA_W-1:0] din;
  logic [NUM_REGS-1:0]             sel;
  logic [NUM_RD-1:0][ADDR_W-1:0]   raddr;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdata;

  rb_wr_select #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sel (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mul_en   (mul_en),
    .mul_data (mul_data),
    .sel      (sel),
    .din      (din)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    rb_cell #(.DATA_W(DATA_W)) u_cell (
      .clk (clk),
      .rst (rst),
      .sel (sel[i]),
      .d   (din[i]),
      .q   (mem[i])
    );
  end

  assign raddr[0] = rd0_addr;
  assign raddr[1] = rd1_addr;
  assign raddr[2] = rd2_addr;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rb_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
      .mem  (mem),
      .addr (raddr[p]),
      .data (rdata[p])
    );
  end

  assign rd0_data = rdata[0];
  assign rd1_data = rdata[1];
  assign rd2_data = rdata[2];

  // R3: a general write outside any product collision lands at its address
  assert_gen_write_R3: assert property (@(negedge clk) disable iff (rst)
    (wr_en && !(mul_en && (wr_addr >= ADDR_W'(HI_IDX))))
      |=> (mem[$past(wr_addr)] == $past(wr_data)));

  // R5: the product halves land in the reserved pair
  assert_mul_pair_R5: assert property (@(negedge clk) disable iff (rst)
    mul_en |=> ((mem[HI_IDX] == $past(mul_data[2*DATA_W-1:DATA_W])) &&
                (mem[LO_IDX] == $past(mul_data[DATA_W-1:0]))));

  // R6: a colliding general write loses to the product
  assert_mul_priority_R6: assert property (@(negedge clk) disable iff (rst)
    (mul_en && wr_en && (wr_addr == ADDR_W'(LO_IDX)))
      |=> (mem[LO_IDX] == $past(mul_data[DATA_W-1:0])));

  // R2: read port 0 reflects the addressed entry at the sampling point
  assert_read0_R2: assert property (@(negedge clk) disable iff (rst)
    1'b1 |-> (rd0_data == mem[rd0_addr]));
endmodule

// File: tb/test_regbank3r.sv
module test_regbank3r;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd0_addr = '0, rd1_addr = '0, rd2_addr = '0;
  logic [31:0] rd0_data, rd1_data, rd2_data;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        mul_en = 1'b0;
  logic [63:0] mul_data = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model [32];

  always #10 clk = ~clk;  // 50 MHz

  regbank3r i_regbank3r (
    .clk(clk), .rst(rst),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .rd2_addr(rd2_addr), .rd2_data(rd2_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mul_en(mul_en), .mul_data(mul_data)
  );

  // Expected content of entry idx after one falling edge
  function automatic logic [31:0] next_val(int idx, logic [31:0] cur, logic r,
      logic we, logic [4:0] wa, logic [31:0] wd, logic me, logic [63:0] md);
    if (r)                   return 32'd0;
    if (me && idx == 30)     return md[63:32];
    if (me && idx == 31)     return md[31:0];
    if (we && wa == idx[4:0]) return wd;
    return cur;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_reads(string req);
    check(req, rd0_data, model[rd0_addr]);
    check(req, rd1_data, model[rd1_addr]);
    check(req, rd2_data, model[rd2_addr]);
  endtask

  // One cycle: drive after rising edge, check old values, then new ones
  task automatic cycle(string req, logic r, logic we, logic [4:0] wa, logic [31:0] wd,
                       logic me, logic [63:0] md, logic [4:0] a0, logic [4:0] a1, logic [4:0] a2);
    @(posedge clk);
    #2;
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd; mul_en = me; mul_data = md;
    rd0_addr = a0; rd1_addr = a1; rd2_addr = a2;
    #1;
    check_reads("R2");
    #5;
    check_reads("R7 before edge");
    @(negedge clk);
    for (int i = 0; i < 32; i++) model[i] = next_val(i, model[i], r, we, wa, wd, me, md);
    #2;
    check_reads(req);
  endtask

  task automatic idle_read(string req, logic [4:0] a0, logic [4:0] a1, logic [4:0] a2);
    cycle(req, 1'b0, 1'b0, 5'd0, 32'd0, 1'b0, 64'd0, a0, a1, a2);
  endtask

  task automatic scan_all(string req);
    for (int a = 0; a < 32; a += 3)
      idle_read(req, 5'(a), 5'((a + 1) % 32), 5'((a + 2) % 32));
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'hxxxx_xxxx;
    void'($urandom(32'd20240611));
    // R1: reset edges clear everything, even with writes offered
    cycle("R1", 1'b1, 1'b1, 5'd7, 32'hdead_beef, 1'b1, 64'h1111_2222_3333_4444, 5'd0, 5'd30, 5'd31);
    cycle("R1", 1'b1, 1'b0, 5'd0, 32'd0, 1'b0, 64'd0, 5'd7, 5'd30, 5'd31);
    scan_all("R1");

    // R3: write every entry, including the reserved pair
    for (int i = 0; i < 32; i++)
      cycle("R3", 1'b0, 1'b1, 5'(i), 32'hA500_0000 + 32'(i * 4099), 1'b0, 64'd0, 5'(i), 5'((i + 31) % 32), 5'd0);
    scan_all("R3");

    // R4: enables low, random address and data, nothing moves
    for (int i = 0; i < 8; i++)
      cycle("R4", 1'b0, 1'b0, 5'($urandom), $urandom, 1'b0, {$urandom, $urandom}, 5'($urandom), 5'($urandom), 5'($urandom));
    scan_all("R4");

    // R5: product into the pair
    cycle("R5", 1'b0, 1'b0, 5'd0, 32'd0, 1'b1, 64'hCAFE_F00D_0123_4567, 5'd30, 5'd31, 5'd29);
    // R6: collisions on each reserved entry, then a non-colliding pairing
    cycle("R6", 1'b0, 1'b1, 5'd30, 32'h0BAD_0BAD, 1'b1, 64'h89AB_CDEF_FEDC_BA98, 5'd30, 5'd31, 5'd0);
    cycle("R6", 1'b0, 1'b1, 5'd31, 32'h0BAD_1111, 1'b1, 64'h1357_9BDF_2468_ACE0, 5'd31, 5'd30, 5'd1);
    cycle("R6", 1'b0, 1'b1, 5'd5,  32'h5555_AAAA, 1'b1, 64'h7777_8888_9999_0000, 5'd5, 5'd30, 5'd31);
    // R7: write and read the same entry across the edge
    cycle("R7 after edge", 1'b0, 1'b1, 5'd12, 32'h1234_5678, 1'b0, 64'd0, 5'd12, 5'd12, 5'd12);

    // Random mix with collisions and idle cycles
    for (int n = 0; n < 3000; n++) begin
      logic we, me, r;
      logic [4:0] wa;
      we = ($urandom % 4) != 0;
      me = ($urandom % 5) == 0;
      r  = ($urandom % 200) == 0;
      wa = (($urandom % 4) == 0) ? 5'(30 + ($urandom % 2)) : 5'($urandom);
      cycle(r ? "R1" : (me ? "R6" : (we ? "R3" : "R4")), r, we, wa, $urandom, me,
            {$urandom, $urandom}, 5'($urandom), 5'($urandom), wa);
    end

    // R1: reset in mid-stream with writes pending
    cycle("R1", 1'b1, 1'b1, 5'd3, 32'hFFFF_FFFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 5'd3, 5'd30, 5'd31);
    scan_all("R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule